// File: doc/BRIEF.md
# Dual-Channel Ramp Converter Sequencer

This block is the digital side of a single-slope (Wilkinson) converter that digitises two analog quantities in one pass: a pulse charge and a fine arrival time. An accepted start command clears a shared ramp counter and lets it advance once per converter clock, in step with an external analog ramp. Two comparator inputs watch that ramp, one for charge and one for fine time. The first rising edge of each comparator freezes the counter value for that channel.

Each captured value is stored and presented in Gray code. A conversion ends when both channels have captured, or when the counter reaches full scale. At full scale, a channel that never fired is given the full-scale code and flags an overflow. A one-cycle done pulse marks the end. The two results then stay valid until the next accepted start. The ramp, the track-and-hold and the comparators are outside the block and appear only as input signals.

With the default 12-bit width, the ramp spans 4096 counts. At a 40 MHz converter clock (25 ns per count) this is about 100 µs.

Top module: `dual_ramp_adc`

## Requirements
- R1: During and immediately after a synchronous active-low reset, busy_o and done_o are 0, both result codes are 0, and both overflow flags are 0.
- R2: When start_i is sampled high at a clock edge while busy_o is 0, that edge is the accept edge. busy_o is 1 after it, and the internal counter reads 0 during the next cycle and increases by one at every later edge while busy.
- R3: A channel sees a rising edge at the k-th clock edge after the accept edge if its comparator was sampled low at the previous edge and high at that edge. The channel then captures the value k-1. With 12 bits, k ranges from 1 to 4096.
- R4: Each result output shows the captured value b in Gray code, b XOR (b >> 1). For example, 7 is shown as 4 and 4095 as 2048 (0x800).
- R5: Only the first rising edge of a comparator in a conversion is captured. Any later fall or rise of that comparator leaves the channel's code unchanged.
- R6: The charge and fine-time channels capture independently from the same counter. One channel's comparator never changes the other channel's code or overflow flag.
- R7: When the second channel captures at edge k, busy_o falls at that same edge, and done_o is high for exactly the one cycle after it.
- R8: If the counter reaches its full-scale value (4095) and a channel has not captured, then at the 4096th edge after the accept edge that channel takes code 4095 (Gray 0x800) and its overflow flag goes to 1. busy_o falls and done_o pulses at that edge. A channel whose comparator rises exactly at that edge captures 4095 without overflow.
- R9: start_i is ignored while busy_o is 1, including at the edge where the conversion finishes. The counter, the captured codes and the end time are unaffected.
- R10: After a conversion, the codes and overflow flags hold their values until the next accept edge. At that edge both codes and both overflow flags are cleared to 0.
- R11: A comparator that is already high when a conversion starts, and stays high, produces no rising edge. That channel therefore ends with the overflow code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock (40 MHz in the target system) |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start command, accepted only when idle |
| cmp_charge_i | input | 1 | Charge comparator output (ramp crossed held charge level) |
| cmp_time_i | input | 1 | Fine-time comparator output (ramp crossed held time level) |
| busy_o | output | 1 | High from the accept edge until the conversion finishes |
| done_o | output | 1 | One-cycle pulse after the conversion finishes |
| charge_gray_o | output | CNT_W | Captured charge code, Gray coded |
| time_gray_o | output | CNT_W | Captured fine-time code, Gray coded |
| charge_ovf_o | output | 1 | Charge comparator never fired; code is full scale |
| time_ovf_o | output | 1 | Fine-time comparator never fired; code is full scale |

## Verification
A counter that is off by one, or that keeps running past a capture, shows as a wrong Gray code at the done pulse. This mismatch is visible at the same instant done_o rises, at most 4096 cycles after the start. A channel that stays armed after its first capture shows the same way: the bench re-toggles each comparator after its capture, so the later edge alters the code before done. A wrong finish condition moves the done pulse away from the expected edge, and the bench compares the count of edges exactly. A start that is not properly ignored restarts the counter, so every code captured after it comes out small.

// File: rtl/wadc_pkg.sv
// Package: shared constants for the dual-channel ramp converter.
// Assumes: exactly two capture channels, indexed as below.
package wadc_pkg;
    localparam int LANE_COUNT = 2;
    localparam int CHARGE_IDX = 0;
    localparam int TIME_IDX   = 1;
endpackage

// File: rtl/wadc_ramp_seq.sv
// Module: wadc_ramp_seq
// Owns the ramp counter and the busy/done sequencing. A start seen while
// idle launches a conversion; the conversion finishes when every channel
// has captured or the counter sits at full scale.
// Assumes: all_hit_i already includes captures happening this cycle.
module wadc_ramp_seq #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             all_hit_i,
    output logic             launch_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             at_full_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] FULL = '1;

    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_q;
    logic             finish;

    // Accept a start only while idle; finish on all captures or full scale.
    always_comb begin
        launch_o  = start_i & ~busy_q;
        at_full_o = busy_q & (cnt_q == FULL);
        finish    = busy_q & (all_hit_i | at_full_o);
    end

    // Advance the counter and keep busy/done state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= finish;
            if (launch_o) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end else if (finish) begin
                busy_q <= 1'b0;
            end else if (busy_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign cnt_o  = cnt_q;

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R2 R9
    ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && !finish) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

    // R2
    launch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |=> (busy_q && cnt_q == '0));
endmodule

// File: rtl/wadc_lane.sv
// Module: wadc_lane
// One capture channel. Detects the first low-to-high transition of its
// comparator while a conversion runs and stores the counter in Gray code.
// If full scale arrives first, stores the full-scale code and flags overflow.
// Assumes: launch_i and at_full_i come from the sequencer, same clock.
module wadc_lane #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_i,
    input  logic             launch_i,
    input  logic             busy_i,
    input  logic             at_full_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             hit_o,
    output logic [CNT_W-1:0] code_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] FULL = '1;

    function automatic logic [CNT_W-1:0] to_gray(input logic [CNT_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    localparam logic [CNT_W-1:0] FULL_GRAY = to_gray(FULL);

    logic             cmp_q;
    logic             hit_q;
    logic             ovf_q;
    logic [CNT_W-1:0] code_q;
    logic             rise;
    logic             take;
    logic             force_full;

    // Edge detect and capture decisions for this cycle.
    always_comb begin
        rise       = cmp_i & ~cmp_q;
        take       = busy_i & ~hit_q & rise;
        force_full = busy_i & ~hit_q & ~rise & at_full_i;
        hit_o      = hit_q | take;
    end

    // Remember the comparator level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cmp_q <= 1'b0;
        else        cmp_q <= cmp_i;
    end

    // Clear on launch, capture once, or fill with full scale.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= 1'b0;
            ovf_q  <= 1'b0;
            code_q <= '0;
        end else if (launch_i) begin
            hit_q  <= 1'b0;
            ovf_q  <= 1'b0;
            code_q <= '0;
        end else if (take) begin
            hit_q  <= 1'b1;
            code_q <= to_gray(cnt_i);
        end else if (force_full) begin
            hit_q  <= 1'b1;
            ovf_q  <= 1'b1;
            code_q <= FULL_GRAY;
        end
    end

    assign code_o = code_q;
    assign ovf_o  = ovf_q;

    // R5 R10
    hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_q && !launch_i) |=> ($stable(code_q) && $stable(ovf_q)));

    // R8
    ovf_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> (hit_q && code_q == FULL_GRAY));

    // R10
    launch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |=> (!hit_q && !ovf_q && code_q == '0));
endmodule

// File: rtl/dual_ramp_adc.sv
// Module: dual_ramp_adc (top)
// Dual-channel single-slope converter sequencer: one shared ramp counter,
// one capture channel per comparator (charge, fine time), Gray-coded results.
// Assumes: comparators are synchronous to clk; ramp is started externally
// in step with the accept edge.
module dual_ramp_adc #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_charge_i,
    input  logic             cmp_time_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [CNT_W-1:0] charge_gray_o,
    output logic [CNT_W-1:0] time_gray_o,
    output logic             charge_ovf_o,
    output logic             time_ovf_o
);
    import wadc_pkg::*;

    logic [LANE_COUNT-1:0] cmp_vec;
    logic [LANE_COUNT-1:0] hit_vec;
    logic [LANE_COUNT-1:0] ovf_vec;
    logic [CNT_W-1:0]      code_arr [LANE_COUNT];
    logic                  launch;
    logic                  at_full;
    logic [CNT_W-1:0]      cnt;

    // Gather comparator inputs in lane order.
    always_comb begin
        cmp_vec[CHARGE_IDX] = cmp_charge_i;
        cmp_vec[TIME_IDX]   = cmp_time_i;
    end

    wadc_ramp_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .all_hit_i (&hit_vec),
        .launch_o  (launch),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .at_full_o (at_full),
        .cnt_o     (cnt)
    );

    for (genvar i = 0; i < LANE_COUNT; i++) begin : g_lane
        wadc_lane #(.CNT_W(CNT_W)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmp_i     (cmp_vec[i]),
            .launch_i  (launch),
            .busy_i    (busy_o),
            .at_full_i (at_full),
            .cnt_i     (cnt),
            .hit_o     (hit_vec[i]),
            .code_o    (code_arr[i]),
            .ovf_o     (ovf_vec[i])
        );
    end

    assign charge_gray_o = code_arr[CHARGE_IDX];
    assign time_gray_o   = code_arr[TIME_IDX];
    assign charge_ovf_o  = ovf_vec[CHARGE_IDX];
    assign time_ovf_o    = ovf_vec[TIME_IDX];

    // R7 R8
    done_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (&hit_vec));

    // R10
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (charge_gray_o == '0 && time_gray_o == '0
                           && !charge_ovf_o && !time_ovf_o));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (!busy_o && !done_o && !charge_ovf_o && !time_ovf_o));
endmodule

// File: tb/sim_dual_ramp_adc.sv
module sim_dual_ramp_adc;
    localparam int W     = 12;
    localparam int FULLV = 4095;
    localparam int NEVER = 5000;
    localparam int NV    = 8;
    // {charge delay, time delay}; NEVER = comparator never rises
    localparam int VEC [NV][2] = '{
        '{0, 0}, '{7, 3}, '{100, 2000}, '{4095, 12},
        '{1, 4094}, '{NEVER, 40}, '{NEVER, NEVER}, '{2500, 2500}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cq = 1'b0, ct = 1'b0;
    logic busy, done, qovf, tovf;
    logic [W-1:0] qg, tg;
    int nchk = 0, nfail = 0;

    always #2 clk = ~clk;

    dual_ramp_adc #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .cmp_charge_i(cq), .cmp_time_i(ct),
        .busy_o(busy), .done_o(done),
        .charge_gray_o(qg), .time_gray_o(tg),
        .charge_ovf_o(qovf), .time_ovf_o(tovf)
    );

    function automatic int gray(input int b);
        return b ^ (b >> 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One conversion; delays count edges after the accept edge (see R3).
    task automatic conv(input int dq, input int dt, input bit mid_start, input bit pre_q);
        int edges = 0;
        bit seen = 0;
        int last, expe, eq, et;
        cq = pre_q;
        @(negedge clk) start = 1'b1;
        @(posedge clk); #1;
        chk(busy == 1'b1, "R2 busy after accept", busy, 1);
        chk(qg == 0 && tg == 0 && !qovf && !tovf, "R10 cleared at accept", qg, 0);
        @(negedge clk) start = 1'b0;
        for (int m = 0; m < NEVER && !seen; m++) begin
            if (m == dq) cq = 1'b1;
            if (m == dq + 3) cq = 1'b0;   // R5 later edges
            if (m == dq + 5) cq = 1'b1;
            if (m == dt) ct = 1'b1;
            if (m == dt + 3) ct = 1'b0;
            if (m == dt + 5) ct = 1'b1;
            start = (mid_start && m == 5);  // R9
            @(posedge clk); #1;
            edges = m + 1;
            if (done) seen = 1;
            else @(negedge clk);
        end
        start = 1'b0;
        last = (dq > dt) ? dq : dt;
        expe = (last + 1 > 4096) ? 4096 : last + 1;
        eq = (dq > FULLV) ? FULLV : dq;
        et = (dt > FULLV) ? FULLV : dt;
        chk(seen && edges == expe, "R7 R8 done edge", edges, expe);
        chk(busy == 1'b0, "R7 busy low at done", busy, 0);
        chk(qg == gray(eq), "R3 R4 R5 charge code", qg, gray(eq));
        chk(tg == gray(et), "R3 R4 R6 time code", tg, gray(et));
        chk(qovf == (dq > FULLV), "R8 charge ovf", qovf, dq > FULLV);
        chk(tovf == (dt > FULLV), "R8 R6 time ovf", tovf, dt > FULLV);
        @(negedge clk) begin cq = 1'b0; ct = 1'b0; end
        @(posedge clk); #1;
        chk(done == 1'b0, "R7 done one cycle", done, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !done && qg == 0 && tg == 0 && !qovf && !tovf, "R1 reset", busy, 0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!busy && !done, "R1 idle after reset", busy, 0);

        for (int i = 0; i < NV; i++) conv(VEC[i][0], VEC[i][1], 1'b0, 1'b0);

        // R9: start pulsed mid-conversion is ignored
        conv(300, 200, 1'b1, 1'b0);

        // R10: results hold while idle
        for (int k = 0; k < 20; k++) begin
            @(negedge clk) cq = k[0];
            ct = ~k[0];
        end
        @(posedge clk); #1;
        chk(qg == gray(300) && tg == gray(200), "R10 hold charge", qg, gray(300));
        chk(tg == gray(200), "R10 hold time", tg, gray(200));
        @(negedge clk) begin cq = 1'b0; ct = 1'b0; end

        // R11: comparator high before start gives overflow
        conv(NEVER, 50, 1'b0, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog R7 actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule